// File: doc/BRIEF.md
# Two-Lane Residue Base Extension Channel

This block produces, for one destination channel of a residue number system, the residue of an integer in a new modulus, starting from scaled residues that every source channel has already computed. A shared broadcast register presents the scaled residues in pairs. Each pair holds element `i` of the lower half and element `i+S/2` of the upper half. S/2 accepted pairs therefore cover all S source channels.

For each pair the block keeps a running sum of the scaled residues in a W-bit overflow accumulator. The number of times that sum wraps past 2^W, which is 0, 1 or 2, becomes the correction count for the step. In the same step a wide signed accumulator gathers both residues times their short signed coefficients. Each coefficient is shifted left by the truncation amount of its row. The step also adds a per-channel bias and subtracts the correction count times the source-base product reduced in the destination modulus. After the last pair the wide sum is folded into `[0, c)` and presented with a one-cycle done pulse.

The block also holds a helper that forms this channel's own scaled residue, `x * inverse mod b`, so that the value can be placed on the broadcast register. All constants are applied as inputs and must stay stable while an extension runs.

Top module: `coxBaseExt`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done`, `resOut` and `xiOwn` are all 0.
- R2: `start` sampled while idle begins an extension and clears both accumulators, so `busy` is 1 from the next cycle. The block then accepts exactly S/2 pairs, one on each clock edge where `xiValid` is 1. Cycles where `xiValid` is 0 do not advance the count.
- R3: For each accepted pair, the W-bit overflow sum `y` becomes `y + xiLo + xiHi`. Its bits above bit W-1 form the correction count `l`, which is always 0, 1 or 2. `y` keeps only its low W bits. `l * mbMod` is subtracted from the wide sum in that same step.
- R4: The pair accepted at step `i` (0 to S/2-1) uses the coefficients of row `i` for `xiLo` and of row `i+S/2` for `xiHi`. Row `r` is held in `coefFlat[r*CW +: CW]` as a CW-bit two's-complement value and in `shiftFlat[r*SHW +: SHW]` as an unsigned shift. Each product is coefficient times residue, shifted left by the row's shift.
- R5: The signed `biasIn` (W+2 bits, two's complement) is added once per accepted pair, so S/2 times per extension.
- R6: After the S/2-th pair has been accepted, `done` is 1 for exactly one cycle, on the second rising edge after the edge that accepts that pair. In that cycle `resOut` equals the wide signed sum reduced modulo `cMod` into `[0, cMod)`. `cMod` must be nonzero.
- R7: On a clock edge where `xiLoad` is 1, `xiOwn` takes `(xRes * bInv) mod bMod`, computed exactly on the 2W-bit product. `bMod` must be nonzero. Otherwise `xiOwn` holds.
- R8: `start` during an extension is ignored, and `xiValid` while idle is ignored. Neither changes the result, `done` or `resOut`.
- R9: `resOut` holds its value from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an extension (honoured only when idle) |
| xiValid | input | 1 | A scaled-residue pair is present this cycle |
| xiLo | input | W | Scaled residue of lower-half channel `i` |
| xiHi | input | W | Scaled residue of upper-half channel `i+S/2` |
| coefFlat | input | S*CW | Signed truncated coefficients, row r at `[r*CW +: CW]` |
| shiftFlat | input | S*SHW | Per-row left shift, row r at `[r*SHW +: SHW]` |
| biasIn | input | W+2 | Signed per-step bias |
| mbMod | input | W | Source-base product reduced in the destination modulus |
| cMod | input | W | Destination modulus |
| xRes | input | W | This channel's source residue |
| bInv | input | W | Precomputed inverse for this channel's source modulus |
| bMod | input | W | This channel's source modulus |
| xiLoad | input | 1 | Form `xiOwn` on this edge |
| busy | output | 1 | An extension is in progress |
| done | output | 1 | One-cycle pulse: `resOut` is new |
| resOut | output | W | Residue in the destination modulus |
| xiOwn | output | W | This channel's scaled residue |

## Verification
Some properties are checked on every cycle. These are: the correction count never exceeds 2 on an accepted pair; the controller's strobes are mutually exclusive; each finishing cycle is followed by a single done pulse; every presented result and every formed scaled residue lies below its modulus. Other behaviours need a reference value and so are left to the bench scenarios. These are: the pairing of rows with the two lanes, the effect of the row shifts and of negative coefficients, the bias being added once per step, the wrap of a negative sum into range, stalls between pairs, and inputs that must be ignored.

// File: rtl/coxBePkg.sv
package coxBePkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_FIN  = 2'd2
  } beStateT;

  typedef struct packed {
    logic clr;  // clear both accumulators
    logic acc;  // fold the current pair in
    logic fin;  // reduce the wide sum and present it
  } beStrobeT;

endpackage

// File: rtl/coxBeCtrl.sv
module coxBeCtrl
  import coxBePkg::*;
#(
  parameter int S    = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            xiValid,
  output beStrobeT        strobe,
  output logic [IDXW-1:0] idx,
  output logic            busy,
  output logic            done
);

  localparam int HALF = S / 2;
  localparam logic [IDXW-1:0] LAST = IDXW'(HALF - 1);

  beStateT state;

  always_comb begin
    strobe.clr = (state == ST_IDLE) && start;
    strobe.acc = (state == ST_ACC) && xiValid;
    strobe.fin = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= strobe.fin;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_ACC;
            idx   <= '0;
          end
        end
        ST_ACC: begin
          if (xiValid) begin
            if (idx == LAST) begin
              state <= ST_FIN;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: no two strobes at once
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clr, strobe.acc, strobe.fin}));

  // R2: the step index never reaches the upper half
  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    idx <= LAST);

  // R6: each finishing cycle yields a done pulse next cycle
  p_fin_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fin |=> done);

  // R6: done is one cycle wide
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/coxBeDatapath.sv
module coxBeDatapath
  import coxBePkg::*;
#(
  parameter int W    = 33,
  parameter int S    = 8,
  parameter int CW   = 25,
  parameter int SHW  = 4,
  parameter int IDXW = 3,
  parameter int ZW   = 77
) (
  input  logic               clk,
  input  logic               rstN,
  input  beStrobeT           strobe,
  input  logic [IDXW-1:0]    idx,
  input  logic [W-1:0]       xiLo,
  input  logic [W-1:0]       xiHi,
  input  logic [S*CW-1:0]    coefFlat,
  input  logic [S*SHW-1:0]   shiftFlat,
  input  logic signed [W+1:0] biasIn,
  input  logic [W-1:0]       mbMod,
  input  logic [W-1:0]       cMod,
  output logic [W-1:0]       resOut
);

  localparam int HALF = S / 2;

  logic signed [CW-1:0] coefArr  [S];
  logic [SHW-1:0]       shiftArr [S];

  for (genvar g = 0; g < S; g++) begin : gRow
    assign coefArr[g]  = coefFlat[g*CW +: CW];
    assign shiftArr[g] = shiftFlat[g*SHW +: SHW];
  end

  logic [W-1:0]         yAcc;
  logic signed [ZW-1:0] zAcc;

  logic [IDXW-1:0]      idxHi;
  logic [W+1:0]         ySum;
  logic [1:0]           lVal;
  logic signed [ZW-1:0] prodLo, prodHi, corrTerm, biasExt, zNext;
  logic signed [ZW-1:0] cExt, remV, resV;

  assign idxHi = idx + IDXW'(HALF);

  // lane products with the row shift restoring the removed zeros
  function automatic logic signed [ZW-1:0] laneTerm(
      input logic [W-1:0] xi, input logic signed [CW-1:0] cf, input logic [SHW-1:0] sh);
    logic signed [ZW-1:0] xiExt, cfExt;
    xiExt = $signed({{(ZW-W){1'b0}}, xi});
    cfExt = {{(ZW-CW){cf[CW-1]}}, cf};
    return (xiExt * cfExt) <<< sh;
  endfunction

  always_comb begin
    ySum     = {2'b00, yAcc} + {2'b00, xiLo} + {2'b00, xiHi};
    lVal     = ySum[W+1:W];
    prodLo   = laneTerm(xiLo, coefArr[idx],   shiftArr[idx]);
    prodHi   = laneTerm(xiHi, coefArr[idxHi], shiftArr[idxHi]);
    corrTerm = $signed({{(ZW-2){1'b0}}, lVal}) * $signed({{(ZW-W){1'b0}}, mbMod});
    biasExt  = {{(ZW-W-2){biasIn[W+1]}}, biasIn};
    zNext    = zAcc + prodLo + prodHi + biasExt - corrTerm;
    cExt     = $signed({{(ZW-W){1'b0}}, cMod});
    remV     = zAcc % cExt;
    resV     = (remV < 0) ? (remV + cExt) : remV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      yAcc   <= '0;
      zAcc   <= '0;
      resOut <= '0;
    end else begin
      if (strobe.clr) begin
        yAcc <= '0;
        zAcc <= '0;
      end else if (strobe.acc) begin
        yAcc <= ySum[W-1:0];
        zAcc <= zNext;
      end
      if (strobe.fin) begin
        resOut <= W'(resV);
      end
    end
  end

  // R3: the correction count of an accepted pair stays within 0..2
  p_corr_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acc |-> (lVal <= 2'd2));

  // R6: a freshly presented residue lies below the destination modulus
  p_res_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fin && cMod != '0) |=> (resOut < $past(cMod)));

  // R9: outside a finishing cycle the presented residue holds
  p_res_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fin |=> $stable(resOut));

endmodule

// File: rtl/coxXiForm.sv
module coxXiForm #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         xiLoad,
  input  logic [W-1:0] xRes,
  input  logic [W-1:0] bInv,
  input  logic [W-1:0] bMod,
  output logic [W-1:0] xiOwn
);

  localparam int PW = 2 * W;

  logic [PW-1:0] prodV, remV;

  always_comb begin
    prodV = {{W{1'b0}}, xRes} * {{W{1'b0}}, bInv};
    remV  = prodV % {{W{1'b0}}, bMod};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) xiOwn <= '0;
    else if (xiLoad) xiOwn <= W'(remV);
  end

  // R7: a formed scaled residue lies below its source modulus
  p_xi_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    (xiLoad && bMod != '0) |=> (xiOwn < $past(bMod)));

endmodule

// File: rtl/coxBaseExt.sv
module coxBaseExt
  import coxBePkg::*;
#(
  parameter int W   = 33,
  parameter int S   = 8,
  parameter int CW  = 25,
  parameter int SHW = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                xiValid,
  input  logic [W-1:0]        xiLo,
  input  logic [W-1:0]        xiHi,
  input  logic [S*CW-1:0]     coefFlat,
  input  logic [S*SHW-1:0]    shiftFlat,
  input  logic signed [W+1:0] biasIn,
  input  logic [W-1:0]        mbMod,
  input  logic [W-1:0]        cMod,
  input  logic [W-1:0]        xRes,
  input  logic [W-1:0]        bInv,
  input  logic [W-1:0]        bMod,
  input  logic                xiLoad,
  output logic                busy,
  output logic                done,
  output logic [W-1:0]        resOut,
  output logic [W-1:0]        xiOwn
);

  localparam int IDXW = $clog2(S);
  localparam int ZW   = W + CW + (1 << SHW) + 3;

  beStrobeT        strobe;
  logic [IDXW-1:0] idx;

  coxBeCtrl #(.S(S), .IDXW(IDXW)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .xiValid(xiValid),
    .strobe(strobe), .idx(idx), .busy(busy), .done(done)
  );

  coxBeDatapath #(.W(W), .S(S), .CW(CW), .SHW(SHW), .IDXW(IDXW), .ZW(ZW)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(idx),
    .xiLo(xiLo), .xiHi(xiHi), .coefFlat(coefFlat), .shiftFlat(shiftFlat),
    .biasIn(biasIn), .mbMod(mbMod), .cMod(cMod), .resOut(resOut)
  );

  coxXiForm #(.W(W)) uXi (
    .clk(clk), .rstN(rstN), .xiLoad(xiLoad),
    .xRes(xRes), .bInv(bInv), .bMod(bMod), .xiOwn(xiOwn)
  );

endmodule

// File: tb/coxBaseExt_test.sv
module coxBaseExt_test;

  localparam int W = 33, S = 8, CW = 25, SHW = 4, HALF = S / 2;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 1'b0, xiValid = 1'b0, xiLoad = 1'b0;
  logic [W-1:0] xiLo = '0, xiHi = '0, mbV = '0, cV = '0, xRes = '0, bInv = '0, bMod = '0;
  logic signed [W+1:0] biasV = '0;
  logic signed [CW-1:0] cfA [S];
  logic [SHW-1:0] shA [S];
  logic [S*CW-1:0] coefFlat;
  logic [S*SHW-1:0] shiftFlat;
  logic busy, done;
  logic [W-1:0] resOut, xiOwn;

  for (genvar g = 0; g < S; g++) begin : gPack
    assign coefFlat[g*CW +: CW]   = cfA[g];
    assign shiftFlat[g*SHW +: SHW] = shA[g];
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  coxBaseExt #(.W(W), .S(S), .CW(CW), .SHW(SHW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .xiValid(xiValid),
    .xiLo(xiLo), .xiHi(xiHi), .coefFlat(coefFlat), .shiftFlat(shiftFlat),
    .biasIn(biasV), .mbMod(mbV), .cMod(cV), .xRes(xRes), .bInv(bInv),
    .bMod(bMod), .xiLoad(xiLoad), .busy(busy), .done(done),
    .resOut(resOut), .xiOwn(xiOwn)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [W-1:0] expQ [$];
  logic [W-1:0] lastRes = '0;

  task automatic check(input bit ok, input string tag, input logic [127:0] got, input logic [127:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s got %0d expected %0d", tag, got, expv);
    end
  endtask

  // reference from the requirements (R3, R4, R5, R6)
  function automatic logic [W-1:0] refExt(input logic [W-1:0] lo [HALF], input logic [W-1:0] hi [HALF]);
    logic [63:0] y = 0;
    logic [63:0] l;
    logic signed [127:0] z = 0, a, b, cfx, cc, r;
    for (int i = 0; i < HALF; i++) begin
      y = y + 64'(lo[i]) + 64'(hi[i]);
      l = y >> W;
      y = y & ((64'd1 << W) - 1);
      a = $signed({95'd0, lo[i]});
      cfx = 128'(cfA[i]);
      a = (a * cfx) <<< shA[i];
      b = $signed({95'd0, hi[i]});
      cfx = 128'(cfA[i+HALF]);
      b = (b * cfx) <<< shA[i+HALF];
      z = z + a + b + 128'(biasV) - $signed({64'd0, l}) * $signed({95'd0, mbV});
    end
    cc = $signed({95'd0, cV});
    r = z % cc;
    if (r < 0) r = r + cc;
    return W'(r);
  endfunction

  // monitor: pops expectations as results appear (R6)
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) check(1'b0, "R6 unexpected done", 128'(resOut), 0);
      else begin
        logic [W-1:0] e;
        e = expQ.pop_front();
        check(resOut == e, "R6 result", 128'(resOut), 128'(e));
        lastRes = e;
      end
    end
  end

  // driver: one extension; stallAt inserts an idle cycle before that pair, startAt raises start with that pair
  task automatic runOp(input logic [W-1:0] lo [HALF], input logic [W-1:0] hi [HALF],
                       input int stallAt, input int startAt);
    expQ.push_back(refExt(lo, hi));
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", 128'(busy), 1);
    for (int i = 0; i < HALF; i++) begin
      if (i == stallAt) begin
        xiValid = 1'b0; xiLo = '1; xiHi = '1;
        @(negedge clk);
        check(busy == 1'b1, "R2 busy during stall", 128'(busy), 1);
      end
      xiValid = 1'b1; xiLo = lo[i]; xiHi = hi[i];
      start = (i == startAt);
      @(negedge clk);
    end
    xiValid = 1'b0; start = 1'b0; xiLo = '0; xiHi = '0;
    check(done == 1'b0, "R6 no early done", 128'(done), 0);
    @(negedge clk);
    check(done == 1'b1, "R6 done timing", 128'(done), 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R6 done one cycle", 128'({busy, done}), 0);
  endtask

  task automatic xiCase(input logic [W-1:0] x, input logic [W-1:0] inv, input logic [W-1:0] m);
    logic [2*W-1:0] p;
    @(negedge clk); xRes = x; bInv = inv; bMod = m; xiLoad = 1'b1;
    @(negedge clk); xiLoad = 1'b0; xRes = '1;
    p = ({{W{1'b0}}, x} * {{W{1'b0}}, inv}) % {{W{1'b0}}, m};
    check(xiOwn == W'(p), "R7 scaled residue", 128'(xiOwn), 128'(p));
    @(negedge clk);
    check(xiOwn == W'(p), "R7 hold without load", 128'(xiOwn), 128'(p));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lo [HALF];
    logic [W-1:0] hi [HALF];
    for (int r = 0; r < S; r++) begin cfA[r] = '0; shA[r] = '0; end
    cV = 33'h1FFFFFFF7; mbV = 33'h12345678F; biasV = 35'sd5;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && resOut == 0 && xiOwn == 0, "R1 in reset",
          128'({busy, done, resOut, xiOwn}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && resOut == 0 && xiOwn == 0, "R1 after reset",
          128'({busy, done, resOut, xiOwn}), 0);

    // R7 cases
    xiCase(33'd5, 33'd7, 33'd11);
    xiCase(33'h1FFFFFFFF, 33'h1ABCDEF01, 33'h1FFFFFFF7);

    // R5: zero coefficients and residues leave only S/2 biases
    for (int i = 0; i < HALF; i++) begin lo[i] = 0; hi[i] = 0; end
    runOp(lo, hi, -1, -1);

    // R3: all-ones residues force corrections of 1 and 2
    for (int r = 0; r < S; r++) begin cfA[r] = CW'(r * 1000 + 7); shA[r] = SHW'(r); end
    for (int i = 0; i < HALF; i++) begin lo[i] = '1; hi[i] = '1; end
    runOp(lo, hi, -1, -1);

    // R4: negative coefficients, large shifts, distinct rows per lane
    for (int r = 0; r < S; r++) begin
      cfA[r] = (r % 2 == 1) ? -CW'(24'h7FFFFF - r * 311) : CW'(24'h3A5C1 + r * 97);
      shA[r] = SHW'(15 - r);
    end
    for (int i = 0; i < HALF; i++) begin lo[i] = W'(64'h1_2345_0000 + i * 64'h0F0F_1234); hi[i] = W'(64'h0_9876_5432 * (i + 1)); end
    runOp(lo, hi, -1, -1);

    // R2: a stall between pairs
    for (int i = 0; i < HALF; i++) begin lo[i] = W'($urandom); hi[i] = W'({$urandom, $urandom}); end
    runOp(lo, hi, 2, -1);

    // R8: start raised mid-extension is ignored
    for (int i = 0; i < HALF; i++) begin lo[i] = W'({$urandom, $urandom}); hi[i] = W'($urandom); end
    runOp(lo, hi, -1, 1);

    // R6: negative bias drives the sum below zero, result wraps into range
    biasV = -35'sd17179869183;
    for (int r = 0; r < S; r++) cfA[r] = -CW'(5);
    for (int i = 0; i < HALF; i++) begin lo[i] = W'(i + 3); hi[i] = W'(i + 9); end
    runOp(lo, hi, 0, -1);

    // R8, R9: pairs offered while idle do nothing; result holds
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); xiValid = 1'b1; xiLo = W'(k * 12345); xiHi = '1;
    end
    @(negedge clk); xiValid = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R8 idle pairs ignored", 128'(busy), 0);
    check(resOut == lastRes, "R9 result held", 128'(resOut), 128'(lastRes));

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R6 every extension produced", 128'(expQ.size()), 0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule